// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits on the host write path of a byte-wide flash-style memory. It monitors each write cycle (write enable, address, data) and recognises the multi-write unlock sequences that guard the device. Four commands are recognised. A three-write prefix grants a protected page load. A six-write sequence starts a chip erase. A second six-write sequence enters the identification mode. A three-write sequence leaves that mode. All commands begin with the same two unlock writes, so one shared state machine follows the common prefix and branches on the third and sixth data bytes.

Writes are forwarded to the page buffer as `page_we_o` only inside a load window. The three-write prefix opens that window while software protection is on, and protection is on from reset. The window closes after a programmable number of cycles with no accepted write. Every forwarded byte must belong to the page of the first byte in the window. A chip erase raises a busy flag for a parameterised number of cycles, and all writes are ignored while it is high. In identification mode the read path returns fixed manufacturer and device codes at the two lowest addresses. Every other read passes the array data through.

Top module: `cmd_unlock_decoder`

## Requirements
- R1: After reset `prot_on_o`=1, and `load_open_o`, `erase_busy_o`, `erase_start_o`, `id_mode_o` and `page_we_o` are all 0.
- R2: The writes 0xAA@0x5555, 0x55@0x2AAA, 0xA0@0x5555 (addresses compared on bits 14..0) set `load_open_o` to 1 from the cycle after the third write. None of those three writes asserts `page_we_o`.
- R3: With protection on and no load window open, a write does not assert `page_we_o` and changes no output.
- R4: Inside a load window, `page_we_o` is high in the same cycle as an accepted write. The first write fixes the page, which is address bits 16..7. A later write to another page gets `page_we_o`=0.
- R5: The window closes LOAD_TIMEOUT cycles after the last accepted write. A write landing exactly LOAD_TIMEOUT cycles after the previous one is accepted and keeps the window open. A write one cycle later is dropped.
- R6: The writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x10@0x5555 give a one-cycle `erase_start_o` pulse and `erase_busy_o`=1 for exactly ERASE_CYCLES cycles, both starting the cycle after the sixth write. While busy, writes assert no `page_we_o` and advance no sequence.
- R7: The same six writes with 0x60 as the last byte set `id_mode_o`. In that mode `rd_data_o` is 0xDA at read address 0 and 0xC1 at read address 1. Every other address, and every read outside the mode, returns `array_data_i`.
- R8: The writes 0xAA@0x5555, 0x55@0x2AAA, 0xF0@0x5555 clear `id_mode_o`.
- R9: Address bits above bit 14 are ignored when matching commands.
- R10: A write that breaks a sequence returns the decoder to idle. It starts a new sequence only if it is itself 0xAA@0x5555.
- R11: Once set, `prot_on_o` stays 1. Completing the prefix sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | One-cycle host write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | ADDR_W | Read address |
| array_data_i | input | 8 | Data read from the array |
| page_we_o | output | 1 | Write forwarded to the page buffer |
| load_open_o | output | 1 | Page load window open |
| erase_start_o | output | 1 | One-cycle chip erase start |
| erase_busy_o | output | 1 | Chip erase in progress |
| prot_on_o | output | 1 | Software protection mode |
| id_mode_o | output | 1 | Identification mode |
| rd_data_o | output | 8 | Read data with ID codes substituted |

## Verification
Two events can fall in the same cycle: the expiry of the load window timer and the arrival of a new page byte. The bench provokes this by writing exactly LOAD_TIMEOUT cycles after the last accepted byte, and again one cycle later. It judges the result by `page_we_o` in the write cycle and by `load_open_o` afterwards. The write must win in the first case and be dropped in the second. A second overlap is a full unlock prefix issued while the erase is busy. The bench checks that no window opens and that no late window opens once busy falls.

// File: rtl/ucd_pkg.sv
package ucd_pkg;
  localparam int MATCH_W = 15;

  typedef enum logic [2:0] {
    ST_IDLE, ST_U1, ST_U2, ST_X3, ST_X4, ST_X5
  } seq_st_e;

  localparam logic [MATCH_W-1:0] ADR_KEY_A = 15'h5555;
  localparam logic [MATCH_W-1:0] ADR_KEY_B = 15'h2AAA;

  localparam logic [7:0] DAT_KEY_A  = 8'hAA;
  localparam logic [7:0] DAT_KEY_B  = 8'h55;
  localparam logic [7:0] DAT_PROT   = 8'hA0;
  localparam logic [7:0] DAT_EXT    = 8'h80;
  localparam logic [7:0] DAT_IDEXIT = 8'hF0;
  localparam logic [7:0] DAT_ERASE  = 8'h10;
  localparam logic [7:0] DAT_IDIN   = 8'h60;
  localparam logic [7:0] ID_MFR     = 8'hDA;
  localparam logic [7:0] ID_DEV     = 8'hC1;
endpackage

// File: rtl/ucd_seq_fsm.sv
module ucd_seq_fsm
  import ucd_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [MATCH_W-1:0] addr_i,
  input  logic [7:0]         data_i,
  output logic               prot_hit_o,
  output logic               erase_hit_o,
  output logic               id_enter_o,
  output logic               id_exit_o
);
  seq_st_e st_q, st_d;

  logic at_a, at_b, key_a, key_b;
  assign at_a  = (addr_i == ADR_KEY_A);
  assign at_b  = (addr_i == ADR_KEY_B);
  assign key_a = at_a && (data_i == DAT_KEY_A);
  assign key_b = at_b && (data_i == DAT_KEY_B);

  always_comb begin
    st_d        = st_q;
    prot_hit_o  = 1'b0;
    erase_hit_o = 1'b0;
    id_enter_o  = 1'b0;
    id_exit_o   = 1'b0;
    if (we_i) begin
      // default on a broken step: restart only on the first key write
      st_d = key_a ? ST_U1 : ST_IDLE;
      unique case (st_q)
        ST_IDLE: ;
        ST_U1: if (key_b) st_d = ST_U2;
        ST_U2: begin
          if (at_a && data_i == DAT_PROT) begin
            prot_hit_o = 1'b1;
            st_d       = ST_IDLE;
          end else if (at_a && data_i == DAT_EXT) begin
            st_d = ST_X3;
          end else if (at_a && data_i == DAT_IDEXIT) begin
            id_exit_o = 1'b1;
            st_d      = ST_IDLE;
          end
        end
        ST_X3: if (key_a) st_d = ST_X4;
        ST_X4: if (key_b) st_d = ST_X5;
        ST_X5: begin
          if (at_a && data_i == DAT_ERASE) begin
            erase_hit_o = 1'b1;
            st_d        = ST_IDLE;
          end else if (at_a && data_i == DAT_IDIN) begin
            id_enter_o = 1'b1;
            st_d       = ST_IDLE;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  // R10: at most one command completes per write
  assert_one_hit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prot_hit_o, erase_hit_o, id_enter_o, id_exit_o}));
  // R10: a completed command always leaves the decoder idle
  assert_idle_after_hit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_hit_o || erase_hit_o || id_enter_o || id_exit_o) |=> st_q == ST_IDLE);
endmodule

// File: rtl/ucd_load_window.sv
module ucd_load_window #(
  parameter int PAGE_W  = 10,
  parameter int TIMEOUT = 30000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              open_i,
  input  logic              we_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              prot_i,
  output logic              open_o,
  output logic              we_o
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic              open_q, have_pg_q;
  logic [PAGE_W-1:0] pg_q;
  logic [CW-1:0]     idle_q;
  logic              take;

  assign take   = open_q && we_i && (!have_pg_q || page_i == pg_q);
  assign we_o   = open_q ? take : (we_i && !prot_i);
  assign open_o = open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q    <= 1'b0;
      have_pg_q <= 1'b0;
      pg_q      <= '0;
      idle_q    <= '0;
    end else if (open_i) begin
      open_q    <= 1'b1;
      have_pg_q <= 1'b0;
      idle_q    <= '0;
    end else if (open_q) begin
      if (take) begin
        // a write on the expiry cycle wins over the timeout
        idle_q    <= '0;
        have_pg_q <= 1'b1;
        pg_q      <= page_i;
      end else if (idle_q == LAST) begin
        open_q <= 1'b0;
        idle_q <= '0;
      end else begin
        idle_q <= idle_q + 1'b1;
      end
    end
  end

  // R5: the idle counter never passes the timeout
  assert_idle_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_q <= LAST);
  // R5: the window closes only after a full idle run
  assert_close_timed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(open_q) |-> $past(idle_q) == LAST);
  // R4: a second page never gets through
  assert_page_lock_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_q && have_pg_q && we_o) |-> page_i == pg_q);
endmodule

// File: rtl/ucd_erase_timer.sv
module ucd_erase_timer #(
  parameter int CYCLES = 5000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic start_o,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= start_i;
      if (start_i)           cnt_q <= CW'(CYCLES);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o  = (cnt_q != '0);
  assign start_o = start_q;

  // R6: the start pulse lasts one cycle
  assert_start_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  // R6: busy ends only after counting down to the last cycle
  assert_busy_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(cnt_q) == CW'(1));
endmodule

// File: rtl/cmd_unlock_decoder.sv
module cmd_unlock_decoder
  import ucd_pkg::*;
#(
  parameter int   ADDR_W       = 17,
  parameter int   PAGE_OFS_W   = 7,
  parameter int   LOAD_TIMEOUT = 30000,
  parameter int   ERASE_CYCLES = 5000000,
  parameter logic PROT_RESET   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [7:0]        array_data_i,
  output logic              page_we_o,
  output logic              load_open_o,
  output logic              erase_start_o,
  output logic              erase_busy_o,
  output logic              prot_on_o,
  output logic              id_mode_o,
  output logic [7:0]        rd_data_o
);
  localparam int PAGE_W = ADDR_W - PAGE_OFS_W;

  logic prot_hit, erase_hit, id_enter, id_exit;
  logic seq_we, win_we, busy, win_open;
  logic prot_q, id_q;

  assign seq_we = wr_en_i && !win_open && !busy;
  assign win_we = wr_en_i && !busy;

  ucd_seq_fsm u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (seq_we),
    .addr_i      (wr_addr_i[MATCH_W-1:0]),
    .data_i      (wr_data_i),
    .prot_hit_o  (prot_hit),
    .erase_hit_o (erase_hit),
    .id_enter_o  (id_enter),
    .id_exit_o   (id_exit)
  );

  ucd_load_window #(.PAGE_W(PAGE_W), .TIMEOUT(LOAD_TIMEOUT)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .open_i (prot_hit),
    .we_i   (win_we),
    .page_i (wr_addr_i[ADDR_W-1:PAGE_OFS_W]),
    .prot_i (prot_q),
    .open_o (win_open),
    .we_o   (page_we_o)
  );

  ucd_erase_timer #(.CYCLES(ERASE_CYCLES)) u_ers (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (erase_hit),
    .start_o (erase_start_o),
    .busy_o  (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_q <= PROT_RESET;
      id_q   <= 1'b0;
    end else begin
      if (prot_hit) prot_q <= 1'b1;
      if (id_enter)     id_q <= 1'b1;
      else if (id_exit) id_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data_o = array_data_i;
    if (id_q && rd_addr_i == ADDR_W'(0)) rd_data_o = ID_MFR;
    if (id_q && rd_addr_i == ADDR_W'(1)) rd_data_o = ID_DEV;
  end

  assign load_open_o  = win_open;
  assign erase_busy_o = busy;
  assign prot_on_o    = prot_q;
  assign id_mode_o    = id_q;

  // R2: a completed prefix opens the window on the next cycle
  assert_open_after_prefix_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_hit |=> win_open);
  // R6: erase command makes the timer busy on the next cycle
  assert_busy_after_erase_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_hit |=> busy && erase_start_o);
  // R6: nothing reaches the page buffer during erase
  assert_no_write_in_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !page_we_o);
  // R8: ID mode only drops after the exit command
  assert_id_exit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(id_q) |-> $past(id_exit));
  // R11: protection never turns off
  assert_prot_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(prot_q));
endmodule

// File: tb/cmd_unlock_decoder_tb_top.sv
`timescale 1ns/1ps
module cmd_unlock_decoder_tb_top;
  localparam int T = 20;
  localparam int E = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [16:0] rd_addr = '0;
  logic [7:0]  arr_data = 8'h3C;
  logic        page_we, load_open, erase_start, erase_busy, prot_on, id_mode;
  logic [7:0]  rd_data;

  int n_run = 0;
  int n_fail = 0;
  logic last_we;
  bit done = 0;

  always #5 clk = ~clk;

  cmd_unlock_decoder #(.LOAD_TIMEOUT(T), .ERASE_CYCLES(E)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .array_data_i(arr_data),
    .page_we_o(page_we), .load_open_o(load_open), .erase_start_o(erase_start),
    .erase_busy_o(erase_busy), .prot_on_o(prot_on), .id_mode_o(id_mode),
    .rd_data_o(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    #2 last_we = page_we;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic prefix();
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0);
  endtask

  task automatic six(input logic [7:0] last);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h80);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, last);
  endtask

  task automatic t_reset();
    chk(prot_on == 1, "R1 prot_on", prot_on, 1);
    chk(load_open == 0, "R1 load_open", load_open, 0);
    chk(erase_busy == 0 && erase_start == 0, "R1 erase", erase_busy, 0);
    chk(id_mode == 0, "R1 id_mode", id_mode, 0);
    chk(page_we == 0, "R1 page_we", page_we, 0);
  endtask

  task automatic t_drop();
    wr(17'h00010, 8'h11);
    chk(last_we == 0, "R3 unprotected write", last_we, 0);
    chk(load_open == 0, "R3 no window", load_open, 0);
  endtask

  task automatic t_prefix();
    wr(17'h05555, 8'hAA); chk(last_we == 0, "R2 key1 fwd", last_we, 0);
    wr(17'h02AAA, 8'h55); chk(last_we == 0, "R2 key2 fwd", last_we, 0);
    wr(17'h05555, 8'hA0); chk(last_we == 0, "R2 key3 fwd", last_we, 0);
    chk(load_open == 1, "R2 window open", load_open, 1);
    chk(prot_on == 1, "R11 prot stays", prot_on, 1);
    idle(T + 2);
    chk(load_open == 0, "R5 idle close", load_open, 0);
  endtask

  task automatic t_page();
    prefix();
    wr(17'h00100, 8'h21); chk(last_we == 1, "R4 first byte", last_we, 1);
    wr(17'h00180, 8'h22); chk(last_we == 0, "R4 other page", last_we, 0);
    wr(17'h0017F, 8'h23); chk(last_we == 1, "R4 same page", last_we, 1);
    idle(T + 2);
  endtask

  task automatic t_timeout();
    prefix();
    wr(17'h00200, 8'h01);
    idle(T - 1);
    chk(load_open == 1, "R5 open before expiry", load_open, 1);
    wr(17'h00201, 8'h02); chk(last_we == 1, "R5 write on expiry cycle", last_we, 1);
    idle(T);
    chk(load_open == 0, "R5 closed", load_open, 0);
    wr(17'h00202, 8'h03); chk(last_we == 0, "R5 late write", last_we, 0);
  endtask

  task automatic t_alias();
    wr(17'h1D555, 8'hAA); wr(17'h0AAAA, 8'h55); wr(17'h0D555, 8'hA0);
    chk(load_open == 1, "R9 high bits ignored", load_open, 1);
    idle(T + 2);
  endtask

  task automatic t_break();
    wr(17'h05555, 8'hAA); wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0);
    chk(load_open == 1, "R10 restart on key", load_open, 1);
    idle(T + 2);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h12); wr(17'h05555, 8'hA0);
    chk(load_open == 0, "R10 broken step", load_open, 0);
    wr(17'h05555, 8'hAA); wr(17'h02AAB, 8'h55); wr(17'h05555, 8'hA0);
    chk(load_open == 0, "R10 wrong address", load_open, 0);
  endtask

  task automatic t_erase();
    int n = 0;
    six(8'h10);
    chk(erase_start == 1, "R6 start pulse", erase_start, 1);
    while (erase_busy) begin
      n++;
      @(negedge clk);
      if (n == 1) chk(erase_start == 0, "R6 pulse width", erase_start, 0);
    end
    chk(n == E, "R6 busy length", n, E);
    six(8'h10);
    wr(17'h00300, 8'h44); chk(last_we == 0, "R6 write in busy", last_we, 0);
    prefix();
    chk(load_open == 0, "R6 prefix in busy", load_open, 0);
    while (erase_busy) @(negedge clk);
    idle(1);
    chk(load_open == 0, "R6 no late window", load_open, 0);
  endtask

  task automatic t_id();
    rd_addr = 17'd0; #1;
    chk(rd_data == 8'h3C, "R7 normal read", rd_data, 8'h3C);
    six(8'h60);
    chk(id_mode == 1, "R7 id entry", id_mode, 1);
    chk(erase_busy == 0, "R7 no erase", erase_busy, 0);
    rd_addr = 17'd0; #1; chk(rd_data == 8'hDA, "R7 mfr code", rd_data, 8'hDA);
    rd_addr = 17'd1; #1; chk(rd_data == 8'hC1, "R7 dev code", rd_data, 8'hC1);
    rd_addr = 17'd2; #1; chk(rd_data == 8'h3C, "R7 other addr", rd_data, 8'h3C);
    rd_addr = 17'h10000; #1; chk(rd_data == 8'h3C, "R7 high addr", rd_data, 8'h3C);
    @(negedge clk);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hF0);
    chk(id_mode == 0, "R8 id exit", id_mode, 0);
    rd_addr = 17'd0; #1; chk(rd_data == 8'h3C, "R8 code gone", rd_data, 8'h3C);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_drop();
    t_prefix();
    t_page();
    t_timeout();
    t_alias();
    t_break();
    t_erase();
    t_id();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule